// File: doc/BRIEF.md
# Cascadable Multicarrier Summation Output Stage

This block forms the composite wideband sample of a multicarrier transmitter. Every clock it adds four per-channel 18-bit two's complement samples to an 18-bit wideband input, which usually comes from an upstream copy of the same stage. It then formats the sum for a DAC or for the next stage in a chain. Two mode bits choose the output format (two's complement or offset binary) and turn saturation clipping on or off. The mode is registered with the data, so a mode change applies to exactly the sample presented in the same cycle.

The stage also carries interleaved complex data. An I/Q phase input marks the incoming samples, and the stage drives a phase flag that marks each output sample as I (low) or Q (high). When the phase input is held low, all data is real. When it is held high, this stage generates the alternating phase itself, which is what the first stage of a chain does. When it toggles every clock, the stage follows it, so samples from chained stages stay paired. The path from the wideband input to the output is always two clocks long, so a chain can be time-aligned by starting each stage two clocks earlier than the next.

The data path is a free-running stream: one sample enters and one leaves on every clock. There is no valid or ready signal, and back-pressure cannot be applied. A producer that cannot keep pace must present zero samples. The output-disable pin is plain control. A tri-state bus is modelled as a data output plus a separate drive-enable output.

Top module: `sumstage_out`

## Requirements
- R1: The output sample equals the sum of the four channel samples and the wideband input, all taken as 18-bit two's complement values. It is formatted per R3 to R7 and appears two clocks after those inputs are sampled. Channel k occupies bits [18k+17:18k] of the channel bus.
- R2: A value on the wideband input with all channels zero reaches the output exactly two clocks later, with no other latency.
- R3: When mode bit 0 (clip enable) is 1 and mode bit 1 (two's complement) is 1, bit 17 of the output is always 0. A sum above 65535 gives 0x0FFFF, and a sum from -65536 to 65535 gives its low 17 bits.
- R4: When clip and two's complement are both enabled, a sum below -65536 gives 0x10000.
- R5: When clip is enabled and mode bit 1 is 0 (offset binary), a too-positive sum gives 0x1FFFF and a too-negative sum gives 0x00000.
- R6: Offset binary is the two's complement result with its data MSB inverted. The data MSB is bit 16 when clip is enabled and bit 17 when it is disabled. A zero sum therefore gives 0x10000 and 0x20000 respectively.
- R7: When clip is disabled, the sum is shifted right arithmetically by one, which rounds toward minus infinity. The low 18 bits are then output, wrapping without saturation.
- R8: Drive-enable output is the inverse of the output-disable input in the same cycle (disable high releases the bus).
- R9: When the phase input is low, the phase flag for that sample is low (real data).
- R10: When the phase input is high and was also high in the previous clock, each sample's phase is the inverse of the previous sample's phase.
- R11: When the phase input differs from its value in the previous clock, the sample's phase equals the phase input. The phase flag appears at the output aligned with its sample, two clocks later.
- R12: Synchronous active-high reset clears the output data and the phase flag to zero. After reset, the stored previous phase input reads as 0.
- R13: The mode bits are sampled together with the data, so each output sample uses the mode present when its inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Bit 1: two's complement output; bit 0: clip enable |
| ch_i | input | 72 | Four packed 18-bit channel samples, channel 0 in the low bits |
| wb_i | input | 18 | Wideband cascade input, two's complement |
| qin_i | input | 1 | I/Q phase input (low, held high, or toggling) |
| oen_i | input | 1 | Output disable, active high |
| bus_o | output | 18 | Composite output sample |
| bus_drive_o | output | 1 | High when the output bus is driven |
| qout_o | output | 1 | Phase flag of the output sample: low I, high Q |

## Verification
A behavioural model predicts every output sample and phase flag, and these are compared on each clock. The bench first drives the wideband input alone and then each channel alone with distinct magnitudes. This separates a latency error from a lane mix-up or a dropped addend. Sums placed exactly on the saturation thresholds and one step past them, in both formats, distinguish an off-by-one limit from a wrong clip code. Large positive and negative sums with clipping off expose wrong rounding or saturation where wrapping is required. The phase input is held low, held high and toggled, and the mode is changed every clock, to show that the phase flag and the format stay with their own sample.

// File: rtl/sumstage_pkg.sv
package sumstage_pkg;

  // Mode word: bit 1 selects two's complement output, bit 0 enables clipping.
  typedef struct packed {
    logic twos_fmt;
    logic clip_en;
  } sum_mode_t;

  // Phase of the sample entering the stage.
  //   input changed since last clock -> follow the input
  //   input held high                -> alternate on our own
  //   input held low                 -> real data (phase 0)
  function automatic logic iq_next_tag(input logic qin,
                                       input logic qin_prev,
                                       input logic tag_prev);
    logic t;
    if (qin != qin_prev) t = qin;
    else if (qin)        t = ~tag_prev;
    else                 t = 1'b0;
    return t;
  endfunction

endpackage

// File: rtl/sumstage_adder.sv
module sumstage_adder #(
  parameter int DATA_W = 18,
  parameter int N_CH   = 4,
  parameter int SUM_W  = DATA_W + $clog2(N_CH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CH*DATA_W-1:0]   ch_i,
  input  logic [DATA_W-1:0]        wb_i,
  output logic signed [SUM_W-1:0]  sum_o
);

  localparam int EXT_W = SUM_W - DATA_W;

  logic signed [SUM_W-1:0] ext_ch [N_CH];
  logic signed [SUM_W-1:0] ext_wb;
  logic signed [SUM_W-1:0] acc;

  // Sign-extend every addend so the full sum can never wrap.
  for (genvar g = 0; g < N_CH; g++) begin : g_ext
    assign ext_ch[g] = {{EXT_W{ch_i[g*DATA_W + DATA_W-1]}}, ch_i[g*DATA_W +: DATA_W]};
  end

  assign ext_wb = {{EXT_W{wb_i[DATA_W-1]}}, wb_i};

  always_comb begin
    acc = ext_wb;
    for (int i = 0; i < N_CH; i++) begin
      acc = acc + ext_ch[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= acc;
  end

endmodule

// File: rtl/sumstage_format.sv
module sumstage_format #(
  parameter int DATA_W = 18,
  parameter int SUM_W  = 21
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [SUM_W-1:0]  sum_i,
  input  logic                     clip_i,
  input  logic                     twos_i,
  output logic [DATA_W-1:0]        out_o
);

  localparam int DW2 = DATA_W - 2;
  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((64'sd1 <<< DW2) - 64'sd1);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM - SUM_W'(1);
  localparam logic [DATA_W-1:0] POS_CODE  = {2'b00, {DW2{1'b1}}};
  localparam logic [DATA_W-1:0] NEG_CODE  = {2'b01, {DW2{1'b0}}};
  localparam logic [DATA_W-1:0] GUARD_MSB = {2'b01, {DW2{1'b0}}};
  localparam logic [DATA_W-1:0] TOP_MSB   = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] clip_word;
  logic [DATA_W-1:0] wrap_word;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    // Saturating path: bit DATA_W-1 is a guard and stays zero.
    if (sum_i > POS_LIM)      clip_word = POS_CODE;
    else if (sum_i < NEG_LIM) clip_word = NEG_CODE;
    else                      clip_word = {1'b0, sum_i[DATA_W-2:0]};
    // Halving path: arithmetic shift by one, then keep DATA_W bits.
    wrap_word = sum_i[DATA_W:1];
    if (clip_i) nxt = twos_i ? clip_word : (clip_word ^ GUARD_MSB);
    else        nxt = twos_i ? wrap_word : (wrap_word ^ TOP_MSB);
  end

  always_ff @(posedge clk) begin
    if (rst) out_o <= '0;
    else     out_o <= nxt;
  end

  AST_GUARD_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    clip_i |=> !out_o[DATA_W-1]); // R3

  AST_POS_SAT_TWOS: assert property (@(posedge clk) disable iff (rst)
    (clip_i && twos_i && (sum_i > POS_LIM)) |=> (out_o == POS_CODE)); // R3

  AST_NEG_SAT_TWOS: assert property (@(posedge clk) disable iff (rst)
    (clip_i && twos_i && (sum_i < NEG_LIM)) |=> (out_o == NEG_CODE)); // R4

  AST_OFFSET_SAT: assert property (@(posedge clk) disable iff (rst)
    (clip_i && !twos_i && (sum_i > POS_LIM)) |=> (out_o == (POS_CODE ^ GUARD_MSB))); // R5

endmodule

// File: rtl/sumstage_iq_track.sv
module sumstage_iq_track
  import sumstage_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic qin_i,
  output logic qout_o
);

  logic qin_prev_q;
  logic tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      qin_prev_q <= 1'b0;
      tag_q      <= 1'b0;
      qout_o     <= 1'b0;
    end else begin
      qin_prev_q <= qin_i;
      tag_q      <= iq_next_tag(qin_i, qin_prev_q, tag_q);
      qout_o     <= tag_q;
    end
  end

  AST_REAL_PHASE_LOW: assert property (@(posedge clk) disable iff (rst)
    !qin_i |=> ##1 !qout_o); // R9

  AST_HELD_HIGH_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    (qin_i && qin_prev_q) |=> (tag_q != $past(tag_q))); // R10

  AST_FOLLOW_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (qin_i != qin_prev_q) |=> (tag_q == $past(qin_i))); // R11

endmodule

// File: rtl/sumstage_out.sv
module sumstage_out
  import sumstage_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int N_CH   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_i,
  input  logic [N_CH*DATA_W-1:0]  ch_i,
  input  logic [DATA_W-1:0]       wb_i,
  input  logic                    qin_i,
  input  logic                    oen_i,
  output logic [DATA_W-1:0]       bus_o,
  output logic                    bus_drive_o,
  output logic                    qout_o
);

  localparam int SUM_W = DATA_W + $clog2(N_CH + 1);

  logic signed [SUM_W-1:0] sum_q;
  sum_mode_t               mode_q;

  // Stage 1: wide sum, mode captured alongside it.
  sumstage_adder #(.DATA_W(DATA_W), .N_CH(N_CH), .SUM_W(SUM_W)) u_adder (
    .clk   (clk),
    .rst   (rst),
    .ch_i  (ch_i),
    .wb_i  (wb_i),
    .sum_o (sum_q)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= sum_mode_t'(mode_i);
  end

  // Stage 2: clip / halve and format.
  sumstage_format #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_format (
    .clk    (clk),
    .rst    (rst),
    .sum_i  (sum_q),
    .clip_i (mode_q.clip_en),
    .twos_i (mode_q.twos_fmt),
    .out_o  (bus_o)
  );

  sumstage_iq_track u_iq (
    .clk    (clk),
    .rst    (rst),
    .qin_i  (qin_i),
    .qout_o (qout_o)
  );

  assign bus_drive_o = !oen_i;

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    ((ch_i == '0) && (wb_i == '0) && (mode_i == 2'b11)) |=> ##1 (bus_o == '0)); // R1

endmodule

// File: tb/sumstage_out_test.sv
module sumstage_out_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 18;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     mode_i = 2'b00;
  logic [N*W-1:0] ch_i = '0;
  logic [W-1:0]   wb_i = '0;
  logic           qin_i = 1'b0;
  logic           oen_i = 1'b0;
  logic [W-1:0]   bus_o;
  logic           bus_drive_o;
  logic           qout_o;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    data;
    bit    q;
    string req;
  } exp_t;
  exp_t exp_q[$];

  bit m_qin_prev = 1'b0;
  bit m_tag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sumstage_out uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .ch_i(ch_i), .wb_i(wb_i),
    .qin_i(qin_i), .oen_i(oen_i), .bus_o(bus_o), .bus_drive_o(bus_drive_o),
    .qout_o(qout_o)
  );

  // Behavioural reference of the formatting rules.
  function automatic int ref_format(int sum, bit clip, bit twos);
    int r;
    if (clip) begin
      int v = sum;
      if (v > 65535) v = 65535;
      if (v < -65536) v = -65536;
      r = v & 'h1FFFF;
      if (!twos) r = r ^ 'h10000;
    end else begin
      r = (sum >>> 1) & 'h3FFFF;
      if (!twos) r = r ^ 'h20000;
    end
    return r;
  endfunction

  task automatic check_now();
    checks++;
    if (bus_drive_o !== !oen_i) begin
      errors++;
      $display("FAIL R8: drive=%b exp=%b", bus_drive_o, !oen_i);
    end
    if (exp_q.size() == 2) begin
      exp_t e = exp_q.pop_front();
      checks++;
      if (bus_o !== W'(e.data) || qout_o !== e.q) begin
        errors++;
        $display("FAIL %s: bus=%h exp=%h qout=%b exp=%b", e.req, bus_o, W'(e.data), qout_o, e.q);
      end
    end
  endtask

  task automatic step(input int c0, input int c1, input int c2, input int c3,
                      input int wb, input bit [1:0] m, input bit qin, input string req);
    exp_t e;
    bit   tg;
    @(negedge clk);
    check_now();
    ch_i   = {W'(c3), W'(c2), W'(c1), W'(c0)};
    wb_i   = W'(wb);
    mode_i = m;
    qin_i  = qin;
    if (qin != m_qin_prev) tg = qin;
    else if (qin)          tg = ~m_tag;
    else                   tg = 1'b0;
    m_tag = tg;
    m_qin_prev = qin;
    e.data = ref_format(c0 + c1 + c2 + c3 + wb, m[0], m[1]);
    e.q    = tg;
    e.req  = req;
    exp_q.push_back(e);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R12: reset state, with inputs busy and phase input high
    qin_i = 1'b1;
    wb_i  = 18'h12345;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (bus_o !== '0 || qout_o !== 1'b0) begin
        errors++;
        $display("FAIL R12: bus=%h exp=0 qout=%b exp=0", bus_o, qout_o);
      end
    end
    rst = 1'b0;
    m_qin_prev = 1'b0;
    m_tag = 1'b0;

    // R2: wideband input alone, several modes
    step(0, 0, 0, 0, 1000, 2'b11, 0, "R2");
    step(0, 0, 0, 0, -3, 2'b10, 0, "R2");
    step(0, 0, 0, 0, 1234, 2'b11, 0, "R2");
    step(0, 0, 0, 0, -20000, 2'b11, 0, "R2");

    // R1: each channel alone, then mixed sums
    step(1000, 0, 0, 0, 0, 2'b11, 0, "R1");
    step(0, 2000, 0, 0, 0, 2'b11, 0, "R1");
    step(0, 0, 3000, 0, 0, 2'b11, 0, "R1");
    step(0, 0, 0, 4000, 0, 2'b11, 0, "R1");
    step(100, 200, -50, 7, 1, 2'b11, 0, "R1");
    step(-131072, 131071, 5, -5, 77, 2'b11, 0, "R1");
    step(12345, -2345, 999, -1, -30000, 2'b11, 0, "R1");

    // R3: positive threshold in two's complement
    step(65535, 0, 0, 0, 0, 2'b11, 0, "R3");
    step(65535, 0, 0, 0, 1, 2'b11, 0, "R3");
    step(40000, 40000, 40000, 40000, 0, 2'b11, 0, "R3");
    step(131071, 131071, 131071, 131071, 131071, 2'b11, 0, "R3");

    // R4: negative threshold
    step(-65536, 0, 0, 0, 0, 2'b11, 0, "R4");
    step(-65536, 0, 0, 0, -1, 2'b11, 0, "R4");
    step(-131072, -131072, -131072, -131072, -131072, 2'b11, 0, "R4");

    // R5: offset binary clip codes
    step(65536, 0, 0, 0, 0, 2'b01, 0, "R5");
    step(131071, 131071, 131071, 131071, 131071, 2'b01, 0, "R5");
    step(-65537, 0, 0, 0, 0, 2'b01, 0, "R5");
    step(-131072, -131072, 0, 0, 0, 2'b01, 0, "R5");

    // R6: offset binary in range, MSB inverted
    step(0, 0, 0, 0, 0, 2'b01, 0, "R6");
    step(0, 0, 0, 0, 0, 2'b00, 0, "R6");
    step(5, 0, 0, 0, 0, 2'b00, 0, "R6");
    step(-7, 0, 0, 0, 0, 2'b01, 0, "R6");
    step(-9, 0, 0, 0, 0, 2'b00, 0, "R6");

    // R7: halving with floor rounding and wrap
    step(1, 0, 0, 0, 0, 2'b10, 0, "R7");
    step(-1, 0, 0, 0, 0, 2'b10, 0, "R7");
    step(131071, 131071, 131071, 131071, 131071, 2'b10, 0, "R7");
    step(-131072, -131072, -131072, -131072, -131072, 2'b10, 0, "R7");

    // R13: mode changes every clock with data fixed
    for (int i = 0; i < 8; i++) begin
      step(70000, 0, 0, 0, 0, 2'(i), 0, "R13");
    end

    // R9: phase input low with busy data
    for (int i = 0; i < 4; i++) begin
      step(i * 11, 0, 0, 0, 0, 2'b11, 0, "R9");
    end

    // R10: phase input held high
    for (int i = 0; i < 8; i++) begin
      step(i, 0, 0, 0, -i, 2'b11, 1, "R10");
    end

    // R11: phase input toggling, then back to low
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, i * 3, 100, 2'b11, 1'(i), "R11");
    end
    step(0, 0, 0, 0, 0, 2'b11, 1, "R11");
    step(0, 0, 0, 0, 0, 2'b11, 0, "R11");

    // R8: output disable toggling while data flows
    oen_i = 1'b1;
    step(10, 0, 0, 0, 0, 2'b11, 0, "R8");
    step(20, 0, 0, 0, 0, 2'b11, 0, "R8");
    oen_i = 1'b0;
    step(30, 0, 0, 0, 0, 2'b11, 0, "R8");

    // drain the pipeline
    step(0, 0, 0, 0, 0, 2'b11, 0, "R1");
    step(0, 0, 0, 0, 0, 2'b11, 0, "R1");
    @(negedge clk);
    check_now();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule